// File: doc/BRIEF.md
# Stereo Frame Merger

The block takes two pixel streams from a matched pair of image sensors that run in lockstep. Each stream carries 12-bit raw Bayer samples and marks the first pixel of a frame and the first pixel of each line. Both streams are written into a ping-pong frame store held inside the block. The most recently completed pair is then played out as one composite image. The composite is arranged either side by side, where each output line is the sensor A line followed by the sensor B line, or top over bottom, where all of sensor A's lines are followed by all of sensor B's lines.

The output behaves like a single parallel image sensor. It provides a pixel enable, frame valid, line valid and a 12-bit data bus. The store side runs on the core clock, and the output advances on every second core clock. Horizontal and vertical blanking lengths come from inputs. The frame size is fixed by parameters.

Top module: `stereo_frame_merger`

## Requirements
- R1: A pixel is stored only when its stream's `*_valid` is high. Storing starts at a pixel that has `*_sof` high, which is row 0, column 0. A pixel with `*_sol` high begins the next row at column 0. Plain valid pixels fill the following columns. Pixels that arrive before a start of frame, and pixels beyond FRAME_W in a line, are ignored.
- R2: With the layout latched as 0 (side by side), each output line is the FRAME_W pixels of sensor A row r followed at once by the FRAME_W pixels of sensor B row r. There are FRAME_H such lines, and sample values pass through unchanged.
- R3: With the layout latched as 1 (top-bottom), the output frame is the FRAME_H rows of sensor A followed by the FRAME_H rows of sensor B. Each line is FRAME_W pixels wide, and sample values pass through unchanged.
- R4: `out_pclk_en` is high on every second core clock. The output signals change only on the clock after a cycle in which `out_pclk_en` is high.
- R5: `out_lv` is high only while `out_fv` is high. `out_fv` falls in the same output period as the last line's `out_lv`, never before it.
- R6: Between two lines of a frame, `out_fv` stays high and `out_lv` stays low for max(`hblank_len`,1) output periods.
- R7: Between two output frames, `out_fv` stays low for at least max(`vblank_len`,1) output periods.
- R8: A completed input pair waits in the write half until the readout in progress ends. The halves then swap, and the frames are output in arrival order. The half being read does not change while `out_fv` is high.
- R9: An input frame whose start of frame (stream A) arrives while a completed pair is still waiting is dropped entirely. `overflow` then goes high and stays high until reset.
- R10: `layout_sel` is sampled only when the halves swap, so a change during readout takes effect from the next output frame.
- R11: While reset is high, `out_fv`, `out_lv`, `out_data` and `overflow` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| layout_sel | input | 1 | 0 side by side, 1 top-bottom |
| hblank_len | input | BLANK_W | Idle output periods between lines |
| vblank_len | input | BLANK_W | Idle output periods between frames |
| a_valid | input | 1 | Sensor A pixel valid |
| a_sof | input | 1 | Sensor A first pixel of frame |
| a_sol | input | 1 | Sensor A first pixel of line |
| a_data | input | PIX_W | Sensor A pixel sample |
| b_valid | input | 1 | Sensor B pixel valid |
| b_sof | input | 1 | Sensor B first pixel of frame |
| b_sol | input | 1 | Sensor B first pixel of line |
| b_data | input | PIX_W | Sensor B pixel sample |
| out_pclk_en | output | 1 | Output pixel enable, every second clock |
| out_fv | output | 1 | Output frame valid |
| out_lv | output | 1 | Output line valid |
| out_data | output | PIX_W | Output pixel sample |
| overflow | output | 1 | Sticky dropped-frame flag |

## Verification
The assertions assume that both sensors deliver their frames in lockstep. They also assume that every accepted frame is complete, with each line of exactly FRAME_W pixels, and that the blanking inputs do not change during a readout. The stimulus meets these assumptions. It drives both streams from one task with identical markers, holds the layout and blanking values steady over each frame except in the deliberate layout-change case, and waits out each readout before it reprograms them. Pixel values encode sensor, frame, row and column, so any misplaced or leaked sample from a dropped frame shows up as a mismatch against the bench's own layout model.

// File: rtl/stereo_merge_pkg.sv
package stereo_merge_pkg;

    typedef enum logic [1:0] {
        OT_IDLE = 2'd0,
        OT_LINE = 2'd1,
        OT_HGAP = 2'd2,
        OT_VGAP = 2'd3
    } out_state_e;

    typedef enum logic {
        LAYOUT_SBS = 1'b0,
        LAYOUT_TB  = 1'b1
    } layout_e;

    // Maps an output coordinate to the source sensor and the offset
    // inside that sensor's frame half.
    function automatic void map_pixel(input layout_e lay, input int x, input int y,
                                      input int w, input int h,
                                      output logic sens, output int offs);
        if (lay == LAYOUT_SBS) begin
            sens = (x >= w);
            offs = y * w + ((x >= w) ? x - w : x);
        end else begin
            sens = (y >= h);
            offs = ((y >= h) ? y - h : y) * w + x;
        end
    endfunction

    function automatic int at_least_one(input int v);
        return (v == 0) ? 1 : v;
    endfunction

endpackage

// File: rtl/stereo_line_writer.sv
module stereo_line_writer #(
    parameter int PIX_W   = 12,
    parameter int FRAME_W = 4,
    parameter int FRAME_H = 3,
    parameter int AW      = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  logic             bank,
    input  logic             valid,
    input  logic             sof,
    input  logic             sol,
    input  logic [PIX_W-1:0] data,
    output logic             we,
    output logic [AW-1:0]    waddr,
    output logic [PIX_W-1:0] wdata,
    output logic             done
);
    localparam int FRAME_PIX = FRAME_W * FRAME_H;
    localparam int CW = $clog2(FRAME_W + 1);
    localparam int RW = $clog2(FRAME_H + 1);

    logic          armed;
    logic [CW-1:0] col_q;
    logic [RW-1:0] row_q;
    logic [CW-1:0] c_sel;
    logic [RW-1:0] r_sel;

    always_comb begin
        we    = 1'b0;
        c_sel = '0;
        r_sel = row_q;
        if (valid && sof) begin
            we    = accept;
            r_sel = '0;
        end else if (valid && armed && sol) begin
            we    = (int'(row_q) < FRAME_H - 1);
            r_sel = row_q + 1'b1;
        end else if (valid && armed && int'(col_q) < FRAME_W) begin
            we    = 1'b1;
            c_sel = col_q;
        end
    end

    assign waddr = AW'(int'(bank) * FRAME_PIX + int'(r_sel) * FRAME_W + int'(c_sel));
    assign wdata = data;
    assign done  = we && (int'(r_sel) == FRAME_H - 1) && (int'(c_sel) == FRAME_W - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
            col_q <= '0;
            row_q <= '0;
        end else begin
            if (valid && sof) begin
                armed <= accept;
                row_q <= '0;
                col_q <= CW'(1);
            end else if (we) begin
                row_q <= r_sel;
                col_q <= c_sel + 1'b1;
            end
            if (done) armed <= 1'b0;
        end
    end
endmodule

// File: rtl/stereo_frame_ram.sv
module stereo_frame_ram #(
    parameter int PIX_W = 12,
    parameter int DEPTH = 24,
    parameter int AW    = 5
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [PIX_W-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [PIX_W-1:0] rdata
);
    logic [PIX_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/stereo_out_timing.sv
module stereo_out_timing
    import stereo_merge_pkg::*;
#(
    parameter int PIX_W   = 12,
    parameter int FRAME_W = 4,
    parameter int FRAME_H = 3,
    parameter int BLANK_W = 6,
    parameter int AW      = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  layout_e            layout,
    input  logic               bank,
    input  logic [BLANK_W-1:0] hblank_len,
    input  logic [BLANK_W-1:0] vblank_len,
    input  logic [PIX_W-1:0]   rdata_a,
    input  logic [PIX_W-1:0]   rdata_b,
    output logic [AW-1:0]      raddr,
    output logic               pclk_en,
    output logic               fv,
    output logic               lv,
    output logic [PIX_W-1:0]   data,
    output logic               rd_done
);
    localparam int FRAME_PIX = FRAME_W * FRAME_H;
    localparam int XW = $clog2(2 * FRAME_W);
    localparam int YW = $clog2(2 * FRAME_H);

    out_state_e         st;
    logic [XW-1:0]      x;
    logic [YW-1:0]      y;
    logic [BLANK_W-1:0] cnt;
    logic               go;
    logic               div;
    logic               sens;
    int                 offs;
    int                 ow;
    int                 oh;
    int                 hb_eff;
    int                 vb_eff;

    always_comb begin
        ow     = (layout == LAYOUT_SBS) ? 2 * FRAME_W : FRAME_W;
        oh     = (layout == LAYOUT_SBS) ? FRAME_H : 2 * FRAME_H;
        hb_eff = at_least_one(int'(hblank_len));
        vb_eff = at_least_one(int'(vblank_len));
        map_pixel(layout, int'(x), int'(y), FRAME_W, FRAME_H, sens, offs);
    end

    assign raddr   = AW'(int'(bank) * FRAME_PIX + offs);
    assign pclk_en = div;
    assign fv      = (st == OT_LINE) || (st == OT_HGAP);
    assign lv      = (st == OT_LINE);
    assign data    = (st == OT_LINE) ? (sens ? rdata_b : rdata_a) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= OT_IDLE;
            x       <= '0;
            y       <= '0;
            cnt     <= '0;
            go      <= 1'b0;
            div     <= 1'b0;
            rd_done <= 1'b0;
        end else begin
            div     <= ~div;
            rd_done <= 1'b0;
            if (div) begin
                case (st)
                    OT_IDLE: if (go) begin
                        st <= OT_LINE;
                        x  <= '0;
                        y  <= '0;
                        go <= 1'b0;
                    end
                    OT_LINE: begin
                        if (int'(x) == ow - 1) begin
                            cnt <= '0;
                            if (int'(y) == oh - 1) st <= OT_VGAP;
                            else begin
                                st <= OT_HGAP;
                                y  <= y + 1'b1;
                            end
                        end else begin
                            x <= x + 1'b1;
                        end
                    end
                    OT_HGAP: begin
                        cnt <= cnt + 1'b1;
                        if (int'(cnt) + 1 >= hb_eff) begin
                            st <= OT_LINE;
                            x  <= '0;
                        end
                    end
                    default: begin
                        cnt <= cnt + 1'b1;
                        if (int'(cnt) + 1 >= vb_eff) begin
                            st      <= OT_IDLE;
                            rd_done <= 1'b1;
                        end
                    end
                endcase
            end
            if (start) go <= 1'b1;
        end
    end
endmodule

// File: rtl/stereo_frame_merger.sv
module stereo_frame_merger
    import stereo_merge_pkg::*;
#(
    parameter int PIX_W   = 12,
    parameter int FRAME_W = 4,
    parameter int FRAME_H = 3,
    parameter int BLANK_W = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               layout_sel,
    input  logic [BLANK_W-1:0] hblank_len,
    input  logic [BLANK_W-1:0] vblank_len,
    input  logic               a_valid,
    input  logic               a_sof,
    input  logic               a_sol,
    input  logic [PIX_W-1:0]   a_data,
    input  logic               b_valid,
    input  logic               b_sof,
    input  logic               b_sol,
    input  logic [PIX_W-1:0]   b_data,
    output logic               out_pclk_en,
    output logic               out_fv,
    output logic               out_lv,
    output logic [PIX_W-1:0]   out_data,
    output logic               overflow
);
    localparam int FRAME_PIX = FRAME_W * FRAME_H;
    localparam int DEPTH     = 2 * FRAME_PIX;
    localparam int AW        = $clog2(DEPTH);
    localparam int NSENS     = 2;

    logic             s_valid [NSENS];
    logic             s_sof   [NSENS];
    logic             s_sol   [NSENS];
    logic [PIX_W-1:0] s_data  [NSENS];
    logic             s_we    [NSENS];
    logic [AW-1:0]    s_waddr [NSENS];
    logic [PIX_W-1:0] s_wdata [NSENS];
    logic             s_done  [NSENS];
    logic [PIX_W-1:0] s_rdata [NSENS];
    logic [NSENS-1:0] done_q;

    logic          pending;
    logic          rd_busy;
    logic          wr_bank;
    logic          rd_bank;
    layout_e       mode_q;
    logic          swap;
    logic          rd_done;
    logic          frame_start;
    logic          pair_done;
    logic [AW-1:0] raddr;

    assign s_valid[0] = a_valid;
    assign s_sof[0]   = a_sof;
    assign s_sol[0]   = a_sol;
    assign s_data[0]  = a_data;
    assign s_valid[1] = b_valid;
    assign s_sof[1]   = b_sof;
    assign s_sol[1]   = b_sol;
    assign s_data[1]  = b_data;

    generate
        for (genvar i = 0; i < NSENS; i++) begin : g_sens
            stereo_line_writer #(
                .PIX_W(PIX_W), .FRAME_W(FRAME_W), .FRAME_H(FRAME_H), .AW(AW)
            ) u_wr (
                .clk(clk), .rst(rst), .accept(~pending), .bank(wr_bank),
                .valid(s_valid[i]), .sof(s_sof[i]), .sol(s_sol[i]), .data(s_data[i]),
                .we(s_we[i]), .waddr(s_waddr[i]), .wdata(s_wdata[i]), .done(s_done[i])
            );
            stereo_frame_ram #(
                .PIX_W(PIX_W), .DEPTH(DEPTH), .AW(AW)
            ) u_ram (
                .clk(clk), .we(s_we[i]), .waddr(s_waddr[i]), .wdata(s_wdata[i]),
                .raddr(raddr), .rdata(s_rdata[i])
            );
        end
    endgenerate

    assign frame_start = a_valid && a_sof;
    assign pair_done   = (done_q[0] | s_done[0]) & (done_q[1] | s_done[1]);
    assign swap        = pending && !rd_busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending  <= 1'b0;
            rd_busy  <= 1'b0;
            wr_bank  <= 1'b0;
            rd_bank  <= 1'b1;
            mode_q   <= LAYOUT_SBS;
            overflow <= 1'b0;
            done_q   <= '0;
        end else begin
            done_q[0] <= done_q[0] | s_done[0];
            done_q[1] <= done_q[1] | s_done[1];
            if (frame_start) begin
                if (pending) overflow <= 1'b1;
                else         done_q   <= '0;
            end
            if (pair_done && !pending) begin
                pending <= 1'b1;
                done_q  <= '0;
            end
            if (rd_done) rd_busy <= 1'b0;
            if (swap) begin
                rd_bank <= wr_bank;
                wr_bank <= ~wr_bank;
                mode_q  <= layout_e'(layout_sel);
                pending <= 1'b0;
                rd_busy <= 1'b1;
            end
        end
    end

    stereo_out_timing #(
        .PIX_W(PIX_W), .FRAME_W(FRAME_W), .FRAME_H(FRAME_H),
        .BLANK_W(BLANK_W), .AW(AW)
    ) u_out (
        .clk(clk), .rst(rst), .start(swap), .layout(mode_q), .bank(rd_bank),
        .hblank_len(hblank_len), .vblank_len(vblank_len),
        .rdata_a(s_rdata[0]), .rdata_b(s_rdata[1]), .raddr(raddr),
        .pclk_en(out_pclk_en), .fv(out_fv), .lv(out_lv), .data(out_data),
        .rd_done(rd_done)
    );
endmodule

// File: rtl/stereo_merger_checker.sv
module stereo_merger_checker #(
    parameter int PIX_W = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             out_pclk_en,
    input logic             out_fv,
    input logic             out_lv,
    input logic [PIX_W-1:0] out_data,
    input logic             overflow,
    input logic             rd_bank,
    input logic             mode_q
);
    assert_lv_in_fv_R5: assert property (@(posedge clk) disable iff (rst)
        out_lv |-> out_fv);

    assert_fv_fall_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(out_fv) |-> $fell(out_lv));

    assert_en_low_R4: assert property (@(posedge clk) disable iff (rst)
        out_pclk_en |=> !out_pclk_en);

    assert_en_high_R4: assert property (@(posedge clk) disable iff (rst)
        !out_pclk_en |=> out_pclk_en);

    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !out_pclk_en |=> ($stable(out_fv) && $stable(out_lv) && $stable(out_data)));

    assert_bank_steady_R8: assert property (@(posedge clk) disable iff (rst)
        out_fv |-> $stable(rd_bank));

    assert_mode_steady_R10: assert property (@(posedge clk) disable iff (rst)
        out_fv |-> $stable(mode_q));

    assert_overflow_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

    always_comb begin
        if (rst == 1'b0 && out_lv == 1'b0) begin
            assert_data_idle_R11: assert (out_data == '0 || out_fv);
        end
    end
endmodule

bind stereo_frame_merger stereo_merger_checker #(.PIX_W(PIX_W)) u_chk (
    .clk(clk), .rst(rst), .out_pclk_en(out_pclk_en), .out_fv(out_fv),
    .out_lv(out_lv), .out_data(out_data), .overflow(overflow),
    .rd_bank(rd_bank), .mode_q(mode_q)
);

// File: tb/stereo_frame_merger_tb.sv
`timescale 1ns/1ps
module stereo_frame_merger_tb;
    localparam int W = 4;
    localparam int H = 3;
    localparam int PW = 12;
    localparam int BW = 6;

    logic clk = 0;
    logic rst = 1;
    logic layout_sel = 0;
    logic [BW-1:0] hblank_len = 1, vblank_len = 1;
    logic a_valid = 0, a_sof = 0, a_sol = 0, b_valid = 0, b_sof = 0, b_sol = 0;
    logic [PW-1:0] a_data = 0, b_data = 0;
    logic out_pclk_en, out_fv, out_lv, overflow;
    logic [PW-1:0] out_data;

    always #2.5 clk = ~clk;

    stereo_frame_merger #(.PIX_W(PW), .FRAME_W(W), .FRAME_H(H), .BLANK_W(BW)) u_dut (
        .clk(clk), .rst(rst), .layout_sel(layout_sel),
        .hblank_len(hblank_len), .vblank_len(vblank_len),
        .a_valid(a_valid), .a_sof(a_sof), .a_sol(a_sol), .a_data(a_data),
        .b_valid(b_valid), .b_sof(b_sof), .b_sol(b_sol), .b_data(b_data),
        .out_pclk_en(out_pclk_en), .out_fv(out_fv), .out_lv(out_lv),
        .out_data(out_data), .overflow(overflow)
    );

    int tests = 0, fails = 0;

    // Expectation queue: frame id and layout per output frame
    int q_id [16];
    int q_mode [16];
    int q_wr = 0, q_rd = 0;

    // Collector state
    int cur_id = 0, cur_mode = 0, k = 0, run = 0, ow = 0;
    int hgap_cnt = 0, vgap_cnt = 0, last_vgap = 0, exp_hgap = 1;
    int frames_done = 0, extra_frames = 0;
    int pix_err = 0, len_err = 0, hgap_err = 0, order_err = 0;
    logic [PW-1:0] first_got = 0, first_exp = 0;
    logic prev_fv = 0, prev_lv = 0;

    function automatic logic [PW-1:0] pxv(input int s, input int f, input int r, input int c);
        logic [PW-1:0] v;
        v = {s[0], f[2:0], r[3:0], c[3:0]};
        return v;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst) begin
            prev_fv = 0;
            prev_lv = 0;
        end else if (out_pclk_en) begin
            if (out_lv && !out_fv) order_err++;
            if (out_fv && !prev_fv) begin
                if (q_rd == q_wr) extra_frames++;
                else begin
                    cur_id = q_id[q_rd % 16];
                    cur_mode = q_mode[q_rd % 16];
                    q_rd++;
                end
                last_vgap = vgap_cnt;
                k = 0;
                run = 0;
                hgap_cnt = 0;
            end
            if (out_lv && !prev_lv && out_fv && prev_fv) begin
                if (hgap_cnt != exp_hgap) hgap_err++;
                hgap_cnt = 0;
            end
            if (out_lv) begin
                int row, c, s, r, col;
                logic [PW-1:0] e;
                ow = (cur_mode == 0) ? 2 * W : W;
                row = k / ow;
                c = k % ow;
                if (cur_mode == 0) begin
                    s = (c >= W) ? 1 : 0;
                    col = c % W;
                    r = row;
                end else begin
                    s = (row >= H) ? 1 : 0;
                    r = row % H;
                    col = c;
                end
                e = pxv(s, cur_id, r, col);
                if (out_data != e) begin
                    if (pix_err == 0) begin
                        first_got = out_data;
                        first_exp = e;
                    end
                    pix_err++;
                end
                k++;
                run++;
            end
            if (!out_lv && prev_lv) begin
                if (run != ow) len_err++;
                run = 0;
            end
            if (out_fv && !out_lv) hgap_cnt++;
            if (!out_fv && prev_fv) begin
                frames_done++;
                if (k != 2 * W * H) len_err++;
                vgap_cnt = 0;
            end
            if (!out_fv) vgap_cnt++;
            prev_fv = out_fv;
            prev_lv = out_lv;
        end
    end

    task automatic expect_frame(input int id, input int mode);
        q_id[q_wr % 16] = id;
        q_mode[q_wr % 16] = mode;
        q_wr++;
    endtask

    task automatic send_frame(input int id);
        for (int r = 0; r < H; r++) begin
            for (int c = 0; c < W; c++) begin
                @(negedge clk);
                a_valid = 1; b_valid = 1;
                a_sof = (r == 0 && c == 0); b_sof = a_sof;
                a_sol = (c == 0); b_sol = a_sol;
                a_data = pxv(0, id, r, c);
                b_data = pxv(1, id, r, c);
            end
            @(negedge clk);
            a_valid = 0; b_valid = 0; a_sof = 0; b_sof = 0; a_sol = 0; b_sol = 0;
            @(negedge clk);
        end
    endtask

    task automatic check_pixels(input string req);
        if (pix_err != 0)
            $display("FAIL %s: first sample got %h expected %h", req, first_got, first_exp);
        chk(pix_err == 0, req, pix_err, 0);
        pix_err = 0;
    endtask

    // Vector table: {layout, hblank, vblank}
    localparam int NV = 4;
    localparam int VEC [NV][3] = '{'{0, 2, 3}, '{1, 1, 2}, '{0, 0, 1}, '{1, 4, 5}};

    initial begin : wdog
        repeat (100000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int base;
        repeat (4) @(negedge clk);
        // R11: reset state
        chk(out_fv == 0 && out_lv == 0, "R11 valids in reset", int'({out_fv, out_lv}), 0);
        chk(out_data == 0, "R11 data in reset", int'(out_data), 0);
        chk(overflow == 0, "R11 overflow in reset", int'(overflow), 0);
        rst = 0;

        // R4: enable every second clock
        begin
            int hi = 0;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (out_pclk_en) hi++;
            end
            chk(hi == 10, "R4 enable rate", hi, 10);
        end

        // R1: pixels before any start of frame are ignored
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            a_valid = 1; b_valid = 1; a_sol = (i == 3); b_sol = a_sol;
            a_data = 12'hFFF; b_data = 12'hEEE;
        end
        @(negedge clk);
        a_valid = 0; b_valid = 0; a_sol = 0; b_sol = 0;

        // Vector loop
        for (int v = 0; v < NV; v++) begin
            base = frames_done;
            layout_sel = VEC[v][0][0];
            hblank_len = BW'(VEC[v][1]);
            vblank_len = BW'(VEC[v][2]);
            exp_hgap = (VEC[v][1] == 0) ? 1 : VEC[v][1];
            expect_frame(v + 1, VEC[v][0]);
            send_frame(v + 1);
            repeat (300) @(negedge clk);
            chk(frames_done - base == 1, "R8 one frame out", frames_done - base, 1);
            check_pixels(VEC[v][0] == 0 ? "R2 side-by-side order (R1 capture)" : "R3 top-bottom order (R1 capture)");
            chk(hgap_err == 0, "R6 line gap", hgap_err, 0);
            chk(order_err == 0 && len_err == 0, "R5 valid ordering and lengths", order_err + len_err, 0);
        end

        // R7/R8: two pairs back to back
        layout_sel = 0; hblank_len = 1; vblank_len = 4; exp_hgap = 1;
        base = frames_done;
        expect_frame(5, 0);
        expect_frame(6, 0);
        send_frame(5);
        send_frame(6);
        repeat (500) @(negedge clk);
        chk(frames_done - base == 2, "R8 queued pair output", frames_done - base, 2);
        check_pixels("R8 arrival order");
        chk(last_vgap >= 4, "R7 frame gap", last_vgap, 4);
        chk(overflow == 0, "R9 no overflow without drop", int'(overflow), 0);

        // R9: third frame arrives while a pair waits
        base = frames_done;
        expect_frame(1, 0);
        expect_frame(2, 0);
        send_frame(1);
        send_frame(2);
        send_frame(3);
        chk(overflow == 1, "R9 overflow set", int'(overflow), 1);
        repeat (600) @(negedge clk);
        chk(frames_done - base == 2 && extra_frames == 0, "R9 dropped frame absent",
            frames_done - base + extra_frames, 2);
        check_pixels("R9 no leaked samples");
        chk(overflow == 1, "R9 overflow sticky", int'(overflow), 1);

        // R10: layout change mid-readout applies to next frame only
        layout_sel = 1; hblank_len = 2; vblank_len = 2; exp_hgap = 2;
        base = frames_done;
        expect_frame(4, 1);
        send_frame(4);
        repeat (30) @(negedge clk);
        layout_sel = 0;
        repeat (300) @(negedge clk);
        expect_frame(5, 0);
        send_frame(5);
        repeat (300) @(negedge clk);
        chk(frames_done - base == 2, "R10 frames out", frames_done - base, 2);
        check_pixels("R10 layout held per frame");

        // R11: reset clears the sticky flag
        @(negedge clk);
        rst = 1;
        @(negedge clk);
        @(negedge clk);
        chk(overflow == 0 && out_fv == 0, "R11 reset clears", int'({overflow, out_fv}), 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule